// File: doc/BRIEF.md
# Dual Timebase Prescaler Chain

This block turns a single bus clock into two streams of one-cycle increment enables, each of which advances its own free-running 16-bit counter. Timebase one is derived purely from the bus clock. A first stage divides it by one of two prescaler families: a fixed family offering divide by 4 or 32, or a programmable family offering every even ratio from 2 to 64. A second stage then divides by a power of two. A bypass setting overrides both stages and simply halves the bus clock.

Timebase two is derived from an external pin. The pin is first brought into the bus clock domain through a flop synchronizer. Its rising edges, its falling edges or both edges can then act as the source. Alternatively, the source can be every bus cycle during which the pin is high; that gated source carries a built-in divide by 8. A power-of-two divider follows whichever source is selected.

Whenever the effective settings of a timebase change, that timebase's divider chain restarts from zero. This keeps the spacing to the next enable predictable. The counters and enables are meant to be used directly by capture and compare logic elsewhere in the timer.

Top module: `tbp_top`

## Requirements
- R1: While `rst` is high, both increment enables are low and both counters read zero.
- R2: With `tb1_bypass` = 1, `tb1_inc` pulses every 2 bus cycles. Changes to the other timebase-one inputs during bypass neither alter this rhythm nor restart it.
- R3: With bypass off and `tb1_enh_en` = 0, the first stage divides by 4 when `tb1_std_sel` = 0 and by 32 when it is 1.
- R4: With bypass off and `tb1_enh_en` = 1, the first stage divides by 2×(`tb1_enh_sel`+1), which covers every even ratio from 2 to 64.
- R5: Outside bypass, the `tb1_inc` period is the first-stage ratio multiplied by 2^`tb1_post_sel`.
- R6: After a change of the effective timebase-one settings, driven in cycle N, the first `tb1_inc` occurs exactly one full period later, at cycle N + period.
- R7: `tb2_src` selects the timebase-two source: 0 counts rising pin edges, 1 counts falling edges, 2 counts both edges.
- R8: With `tb2_src` = 3, each bus cycle with the synchronized pin high is one source tick, and an extra divide by 8 is applied. While the pin stays low, `tb2_inc` stays low and `tb2_count` holds.
- R9: The timebase-two source is further divided by 2^`tb2_post_sel`.
- R10: Each counter advances by exactly one, modulo 2^16, on every cycle its increment enable is high, and holds its value otherwise.
- R11: `tb1_inc` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external timing pin |
| tb1_bypass | input | 1 | 1: timebase one is the bus clock divided by 2 |
| tb1_enh_en | input | 1 | 1: programmable prescaler, 0: fixed prescaler |
| tb1_enh_sel | input | 5 | Programmable ratio code, divide by 2×(code+1) |
| tb1_std_sel | input | 1 | Fixed prescaler: 0 gives /4, 1 gives /32 |
| tb1_post_sel | input | 2 | Timebase-one final divide by 2^code |
| tb2_src | input | 2 | 0 rise, 1 fall, 2 both edges, 3 gated bus clock |
| tb2_post_sel | input | 2 | Timebase-two final divide by 2^code |
| tb1_inc | output | 1 | Timebase-one increment enable |
| tb2_inc | output | 1 | Timebase-two increment enable |
| tb1_count | output | 16 | Timebase-one counter |
| tb2_count | output | 16 | Timebase-two counter |

## Verification
The assertions check on every cycle the properties that need only a short window. These are the counter stepping and holding, single-cycle pulses on timebase one, the strict alternation under bypass, the silence of the gated source while the synchronized pin is low, and the cleared state during reset.

Division ratios span hundreds of cycles, so only the bench's scenarios can show them. This covers the fixed and programmable prescaler values, the post dividers, the exact delay to the first enable after a restart, and the edge-mode periods under a toggling pin. The bench measures the spacing between enables and compares it with ratios it computes from the settings.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    localparam int ENH_W   = 5;
    localparam int PRE_W   = ENH_W + 2;
    localparam int POST_W  = 2;
    localparam int POST_DW = 4;
    localparam int GATE_DIV = 8;

    typedef enum logic [1:0] {
        SRC_RISE  = 2'd0,
        SRC_FALL  = 2'd1,
        SRC_BOTH  = 2'd2,
        SRC_GATED = 2'd3
    } src_e;

    typedef struct packed {
        logic              bypass;
        logic              enh_en;
        logic [ENH_W-1:0]  enh_sel;
        logic              std_sel;
        logic [POST_W-1:0] post;
    } tb1_cfg_t;

    typedef struct packed {
        src_e              src;
        logic [POST_W-1:0] post;
    } tb2_cfg_t;

    // Clear every field that has no effect in the current mode, so that
    // edits to an ignored field never look like a settings change.
    function automatic tb1_cfg_t tb1_norm(tb1_cfg_t c);
        tb1_cfg_t r;
        r = c;
        if (c.bypass) begin
            r = '0;
            r.bypass = 1'b1;
        end else if (c.enh_en) begin
            r.std_sel = 1'b0;
        end else begin
            r.enh_sel = '0;
        end
        return r;
    endfunction

    function automatic logic [PRE_W-1:0] tb1_pre(tb1_cfg_t c);
        logic [PRE_W-1:0] r;
        if (c.bypass)
            r = PRE_W'(2);
        else if (c.enh_en)
            r = {1'b0, c.enh_sel, 1'b0} + PRE_W'(2);
        else if (c.std_sel)
            r = PRE_W'(32);
        else
            r = PRE_W'(4);
        return r;
    endfunction

    function automatic logic [POST_DW-1:0] post_div(logic [POST_W-1:0] s);
        return POST_DW'(1) << s;
    endfunction

endpackage

// File: rtl/tbp_pin_sync.sv
module tbp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/tbp_div.sv
module tbp_div #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         tick_in,
    input  logic [W-1:0] div,
    output logic         tick_out
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic         last;

    assign last     = (cnt == div - ONE);
    assign tick_out = tick_in & last & ~restart;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick_in)
            cnt <= last ? '0 : cnt + ONE;
    end
endmodule

// File: rtl/tbp_counter.sv
module tbp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/tbp_top.sv
module tbp_top
    import tbp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic             tb1_bypass,
    input  logic             tb1_enh_en,
    input  logic [4:0]       tb1_enh_sel,
    input  logic             tb1_std_sel,
    input  logic [1:0]       tb1_post_sel,
    input  logic [1:0]       tb2_src,
    input  logic [1:0]       tb2_post_sel,
    output logic             tb1_inc,
    output logic             tb2_inc,
    output logic [CNT_W-1:0] tb1_count,
    output logic [CNT_W-1:0] tb2_count
);
    localparam int NTB = 2;

    // ---------------- timebase one ----------------
    tb1_cfg_t         c1_raw, c1, c1_q;
    logic             restart1;
    logic [PRE_W-1:0] pre1;
    logic [POST_DW-1:0] post1;
    logic             pre1_tick;

    always_comb begin
        c1_raw.bypass  = tb1_bypass;
        c1_raw.enh_en  = tb1_enh_en;
        c1_raw.enh_sel = tb1_enh_sel;
        c1_raw.std_sel = tb1_std_sel;
        c1_raw.post    = tb1_post_sel;
        c1    = tb1_norm(c1_raw);
        pre1  = tb1_pre(c1);
        post1 = c1.bypass ? POST_DW'(1) : post_div(c1.post);
    end

    always_ff @(posedge clk) begin
        c1_q <= c1;
    end

    assign restart1 = !rst && (c1 != c1_q);

    tbp_div #(.W(PRE_W)) u_pre1 (
        .clk(clk), .rst(rst), .restart(restart1),
        .tick_in(1'b1), .div(pre1), .tick_out(pre1_tick)
    );

    tbp_div #(.W(POST_DW)) u_post1 (
        .clk(clk), .rst(rst), .restart(restart1),
        .tick_in(pre1_tick), .div(post1), .tick_out(tb1_inc)
    );

    // ---------------- timebase two ----------------
    tb2_cfg_t           c2, c2_q;
    logic               restart2;
    logic               pin_lvl, pin_rise, pin_fall;
    logic               src_tick, gate_tick;
    logic [POST_DW-1:0] gate_div, post2;

    tbp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    always_comb begin
        c2.src  = src_e'(tb2_src);
        c2.post = tb2_post_sel;
        unique case (c2.src)
            SRC_RISE:  src_tick = pin_rise;
            SRC_FALL:  src_tick = pin_fall;
            SRC_BOTH:  src_tick = pin_rise | pin_fall;
            default:   src_tick = pin_lvl;
        endcase
        gate_div = (c2.src == SRC_GATED) ? POST_DW'(GATE_DIV) : POST_DW'(1);
        post2    = post_div(c2.post);
    end

    always_ff @(posedge clk) begin
        c2_q <= c2;
    end

    assign restart2 = !rst && (c2 != c2_q);

    tbp_div #(.W(POST_DW)) u_gate2 (
        .clk(clk), .rst(rst), .restart(restart2),
        .tick_in(src_tick), .div(gate_div), .tick_out(gate_tick)
    );

    tbp_div #(.W(POST_DW)) u_post2 (
        .clk(clk), .rst(rst), .restart(restart2),
        .tick_in(gate_tick), .div(post2), .tick_out(tb2_inc)
    );

    // ---------------- counters ----------------
    logic [NTB-1:0]   inc_v;
    logic [CNT_W-1:0] cnt_v [NTB];

    assign inc_v = {tb2_inc, tb1_inc};

    genvar t;
    generate
        for (t = 0; t < NTB; t++) begin : g_cnt
            tbp_counter #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst(rst), .inc(inc_v[t]), .count(cnt_v[t])
            );
        end
    endgenerate

    assign tb1_count = cnt_v[0];
    assign tb2_count = cnt_v[1];
endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tb1_bypass,
    input logic             tb1_inc,
    input logic             tb2_inc,
    input logic [CNT_W-1:0] tb1_count,
    input logic [CNT_W-1:0] tb2_count,
    input logic [1:0]       tb2_src,
    input logic             pin_lvl
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (tb1_count == '0 && tb2_count == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!tb1_inc && !tb2_inc));

    // R10
    tb1_step_chk: assert property (@(posedge clk) disable iff (rst)
        tb1_inc |=> tb1_count == $past(tb1_count) + CNT_W'(1));

    // R10
    tb1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tb1_inc |=> $stable(tb1_count));

    // R10
    tb2_step_chk: assert property (@(posedge clk) disable iff (rst)
        tb2_inc |=> tb2_count == $past(tb2_count) + CNT_W'(1));

    // R10
    tb2_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tb2_inc |=> $stable(tb2_count));

    // R11
    tb1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tb1_inc |=> !tb1_inc);

    // R2
    bypass_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (tb1_bypass && $past(tb1_bypass) && $past(tb1_bypass, 2) && !$past(rst))
            |-> (tb1_inc != $past(tb1_inc)));

    // R8
    gated_low_chk: assert property (@(posedge clk) disable iff (rst)
        (tb2_src == 2'd3 && !pin_lvl) |-> !tb2_inc);
endmodule

bind tbp_top tbp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tb1_bypass(tb1_bypass),
    .tb1_inc(tb1_inc), .tb2_inc(tb2_inc),
    .tb1_count(tb1_count), .tb2_count(tb2_count),
    .tb2_src(tb2_src), .pin_lvl(pin_lvl)
);

// File: tb/tbp_top_tb.sv
`timescale 1ns/1ps
module tbp_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        ext_pin = 1'b0;
    logic        tb1_bypass, tb1_enh_en, tb1_std_sel;
    logic [4:0]  tb1_enh_sel;
    logic [1:0]  tb1_post_sel, tb2_src, tb2_post_sel;
    logic        tb1_inc, tb2_inc;
    logic [15:0] tb1_count, tb2_count;

    int n_chk = 0;
    int n_fail = 0;
    int half = 0;
    bit hold_val = 1'b0;

    always #2 clk = ~clk;

    tbp_top u_dut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin),
        .tb1_bypass(tb1_bypass), .tb1_enh_en(tb1_enh_en),
        .tb1_enh_sel(tb1_enh_sel), .tb1_std_sel(tb1_std_sel),
        .tb1_post_sel(tb1_post_sel), .tb2_src(tb2_src),
        .tb2_post_sel(tb2_post_sel), .tb1_inc(tb1_inc), .tb2_inc(tb2_inc),
        .tb1_count(tb1_count), .tb2_count(tb2_count)
    );

    // pin driver: toggles every 'half' cycles, or holds hold_val
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (half > 0) begin
                ph++;
                if (ph >= half) begin
                    ext_pin = ~ext_pin;
                    ph = 0;
                end
            end else begin
                ext_pin = hold_val;
                ph = 0;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp1(bit b, bit e, int s, bit st, int p);
        int pre;
        if (b) return 2;
        pre = e ? 2 * (s + 1) : (st ? 32 : 4);
        return pre << p;
    endfunction

    function automatic int key1(bit b, bit e, int s, bit st, int p);
        if (b) return 1;
        return (e ? 2 : 0) | ((e ? s : 0) << 2) | ((e ? 0 : int'(st)) << 8) | (p << 10);
    endfunction

    function automatic bit get_inc(int which);
        return (which == 1) ? tb1_inc : tb2_inc;
    endfunction

    function automatic int get_cnt(int which);
        return (which == 1) ? int'(tb1_count) : int'(tb2_count);
    endfunction

    // drive tb1 at a falling edge; if the effective setting changed, check
    // the distance to the first enable (R6)
    task automatic set_tb1(bit b, bit e, int s, bit st, int p, string req);
        int old_k, k, ex;
        old_k = key1(tb1_bypass, tb1_enh_en, int'(tb1_enh_sel), tb1_std_sel, int'(tb1_post_sel));
        @(negedge clk);
        tb1_bypass = b; tb1_enh_en = e; tb1_enh_sel = 5'(s);
        tb1_std_sel = st; tb1_post_sel = 2'(p);
        ex = exp1(b, e, s, st, p);
        if (old_k != key1(b, e, s, st, p)) begin
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!tb1_inc && k < 3000);
            check(k == ex, {"R6 first enable after change ", req}, k, ex);
        end
    endtask

    // measure n gaps between enables and the counter advance (R10)
    task automatic gaps(int which, int ex, int n, string req);
        int k, c0, c1;
        k = 0;
        while (!get_inc(which) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        c0 = get_cnt(which);
        for (int i = 0; i < n; i++) begin
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!get_inc(which) && k < 3000);
            check(k == ex, {req, " enable spacing"}, k, ex);
        end
        c1 = get_cnt(which);
        check(((c1 - c0) & 16'hFFFF) == n, "R10 counter advance", (c1 - c0) & 16'hFFFF, n);
    endtask

    task automatic set_tb2(int src, int p);
        @(negedge clk);
        tb2_src = 2'(src);
        tb2_post_sel = 2'(p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt_a, ones, b, e, s, st, p, src, h;
        string rq;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        tb1_bypass = 0; tb1_enh_en = 0; tb1_enh_sel = 0; tb1_std_sel = 0; tb1_post_sel = 0;
        tb2_src = 0; tb2_post_sel = 0;
        repeat (6) @(negedge clk);
        // R1
        check(!tb1_inc && !tb2_inc, "R1 enables in reset", int'({tb1_inc, tb2_inc}), 0);
        check(tb1_count == 0 && tb2_count == 0, "R1 counters in reset",
              int'(tb1_count) + int'(tb2_count), 0);
        rst = 1'b0;

        // R3 fixed /4 right after reset
        gaps(1, 4, 3, "R3 fixed /4");
        set_tb1(0, 0, 0, 1, 0, "R3");
        gaps(1, 32, 3, "R3 fixed /32");

        // R2 bypass, then edits to ignored fields must not disturb the rhythm
        set_tb1(1, 0, 0, 0, 0, "R2");
        gaps(1, 2, 4, "R2 bypass");
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            tb1_enh_en = 1'($urandom);
            tb1_enh_sel = 5'($urandom);
            tb1_std_sel = 1'($urandom);
            tb1_post_sel = 2'($urandom);
            if (tb1_inc) ones++;
        end
        check(ones == 10, "R2 ignored fields during bypass", ones, 10);

        // R4 programmable ratios
        set_tb1(0, 1, 0, 0, 0, "R4");
        gaps(1, 2, 3, "R4 /2");
        set_tb1(0, 1, 31, 0, 0, "R4");
        gaps(1, 64, 3, "R4 /64");
        set_tb1(0, 1, 10, 0, 0, "R4");
        gaps(1, 22, 3, "R4 /22");

        // R5 post divider
        set_tb1(0, 1, 31, 0, 3, "R5");
        gaps(1, 512, 2, "R5 /64 then /8");
        set_tb1(0, 0, 0, 0, 2, "R5");
        gaps(1, 16, 3, "R5 /4 then /4");

        // random timebase-one settings
        for (int i = 0; i < 16; i++) begin
            b = ($urandom % 4 == 0);
            e = $urandom % 2;
            s = $urandom % 32;
            st = $urandom % 2;
            p = $urandom % 4;
            rq = b ? "R2" : (e ? "R4/R5" : "R3/R5");
            set_tb1(b[0], e[0], s, st[0], p, rq);
            gaps(1, exp1(b[0], e[0], s, st[0], p), 3, rq);
        end

        // R7 edge sources
        half = 5;
        set_tb2(0, 0);
        gaps(2, 10, 3, "R7 rising edges");
        set_tb2(1, 1);
        gaps(2, 20, 3, "R7 falling edges R9");
        half = 4;
        set_tb2(2, 2);
        gaps(2, 16, 3, "R7 both edges R9");
        half = 3;
        set_tb2(0, 3);
        gaps(2, 48, 2, "R9 rising /8");

        // R8 gated source
        half = 0;
        hold_val = 1'b1;
        set_tb2(3, 0);
        gaps(2, 8, 3, "R8 gated high");
        set_tb2(3, 2);
        gaps(2, 32, 3, "R8 gated R9");
        hold_val = 1'b0;
        repeat (10) @(negedge clk);
        cnt_a = int'(tb2_count);
        ones = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tb2_inc) ones++;
        end
        check(ones == 0, "R8 gated pin low enables", ones, 0);
        check(int'(tb2_count) == cnt_a, "R8 gated pin low counter", int'(tb2_count), cnt_a);

        // random timebase-two settings
        for (int i = 0; i < 8; i++) begin
            src = $urandom % 4;
            h = 2 + $urandom % 8;
            p = $urandom % 4;
            if (src == 3) begin
                half = 0;
                hold_val = 1'b1;
            end else begin
                half = h;
            end
            set_tb2(src, p);
            if (src == 3)
                gaps(2, 8 << p, 2, "R8 random");
            else if (src == 2)
                gaps(2, h << p, 2, "R7 random");
            else
                gaps(2, (2 * h) << p, 2, "R7 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule